// File: doc/BRIEF.md
# Four-Cluster Split Register and ALU Datapath

This block executes one already-decoded wide instruction bundle per clock. The bundle holds one slot for each cluster. Each cluster owns a bank of general registers and one ALU, and the clusters form a ring. A slot names an operation, two source operands and a destination register. A source operand can come from one of four places: the slot's own bank, the bank of the cluster to its left, the bank of the cluster to its right, or a literal carried in the slot. The result is always written back into the slot's own bank. Each bank therefore needs only one write port per clock.

Each bank has two read ports for its own slot. It has one more read port for each of its two ring neighbours. A slot may use at most one of those neighbour ports per bundle. All reads in a bundle see register contents from before that bundle's write-back. The results, carry bits and error flags are registered and appear one clock after the bundle. The same clock edge commits the register writes.

Top module: `vliw_cluster_dp`

## Requirements
- R1: A synchronous active-high reset clears every register of every bank to zero. While reset is high and on the first clock after it, `res_valid`, `res_err`, `res_carry` and `res_data` are all zero.
- R2: The opcode is 3 bits. 0 adds A+B modulo 2^16 with carry set to the carry out. 1 computes A−B modulo 2^16 with carry set to the borrow (1 when A<B unsigned). 2 is AND, 3 is OR and 4 is XOR. 5 passes A. The logic and pass operations give carry 0.
- R3: A 2-bit source selector picks the operand. 0 reads the own bank. 1 reads the left neighbour's bank, which is cluster (s−1) mod 4, so cluster 0's left is cluster 3. 2 reads the right neighbour's bank, which is cluster (s+1) mod 4. 3 takes the slot's 16-bit literal `slot_imm`. In each case the register index is the slot's register field for that source.
- R4: A legal enabled slot writes its result only into register `dst` of its own bank. Banks of other clusters are untouched. The written value is visible to reads from the next bundle on.
- R5: Every read in a bundle returns the value held before that bundle, even when a slot of the same bundle writes that register.
- R6: A slot is illegal when both selectors are neighbour reads (1 or 2) or when the opcode is 6 or 7. An enabled illegal slot gives `res_err`=1 and `res_valid`=0 on the next clock and writes no register.
- R7: All four slots execute in the same bundle, independently of one another.
- R8: A slot with `slot_en` low writes nothing. On the next clock it shows `res_valid`=0 and `res_err`=0.
- R9: Outputs of a slot appear on the clock after the bundle is presented, and they hold until the next bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | N_CL | Per-slot enable |
| slot_op | input | N_CL*3 | Per-slot opcode |
| slot_dst | input | N_CL*AW | Per-slot destination index in own bank |
| slot_sel_a | input | N_CL*2 | Per-slot source A selector |
| slot_reg_a | input | N_CL*AW | Per-slot source A register index |
| slot_sel_b | input | N_CL*2 | Per-slot source B selector |
| slot_reg_b | input | N_CL*AW | Per-slot source B register index |
| slot_imm | input | N_CL*REG_W | Per-slot literal operand |
| res_valid | output | N_CL | Slot result valid, registered |
| res_err | output | N_CL | Slot bundle illegal, registered |
| res_carry | output | N_CL | Carry or borrow of slot result, registered |
| res_data | output | N_CL*REG_W | Slot results, registered |

## Verification
The bench builds the block with its defaults: four clusters and sixteen 16-bit registers per bank. At this size the ring wraps between clusters 3 and 0, so both wrap directions are exercised. The 16-bit add can overflow, and the subtract can borrow. Register contents are loaded through literal operands and read back with pass operations on the result ports. This makes cross-bank isolation, write suppression and read-before-write ordering observable at the edge of the block.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  // operation codes
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_XOR  = 3'd4;
  localparam logic [2:0] OP_PASS = 3'd5;
  localparam logic [2:0] OP_LAST = OP_PASS;

  // operand source selectors
  localparam logic [1:0] SRC_OWN   = 2'd0;
  localparam logic [1:0] SRC_LEFT  = 2'd1;
  localparam logic [1:0] SRC_RIGHT = 2'd2;
  localparam logic [1:0] SRC_IMM   = 2'd3;

  function automatic logic is_nbr(input logic [1:0] sel);
    return (sel == SRC_LEFT) || (sel == SRC_RIGHT);
  endfunction
endpackage

// File: rtl/vliw_regbank.sv
module vliw_regbank #(
  parameter int REG_W = 16,
  parameter int N_REG = 16,
  localparam int AW = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [AW-1:0]    ra_a,
  input  logic [AW-1:0]    ra_b,
  input  logic [AW-1:0]    ra_up,
  input  logic [AW-1:0]    ra_dn,
  output logic [REG_W-1:0] rd_a,
  output logic [REG_W-1:0] rd_b,
  output logic [REG_W-1:0] rd_up,
  output logic [REG_W-1:0] rd_dn
);
  logic [REG_W-1:0] mem [N_REG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_REG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // asynchronous reads: values from before this cycle's write
  assign rd_a  = mem[ra_a];
  assign rd_b  = mem[ra_b];
  assign rd_up = mem[ra_up];
  assign rd_dn = mem[ra_dn];
endmodule

// File: rtl/vliw_opsel.sv
module vliw_opsel
  import vliw_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int AW    = 4
) (
  input  logic [2:0]       op,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  input  logic [AW-1:0]    reg_a,
  input  logic [AW-1:0]    reg_b,
  input  logic [REG_W-1:0] imm,
  input  logic [REG_W-1:0] own_a,
  input  logic [REG_W-1:0] own_b,
  input  logic [REG_W-1:0] left_d,
  input  logic [REG_W-1:0] right_d,
  output logic [AW-1:0]    nbr_addr,
  output logic [REG_W-1:0] opnd_a,
  output logic [REG_W-1:0] opnd_b,
  output logic             illegal
);
  logic nbr_a, nbr_b;

  assign nbr_a    = is_nbr(sel_a);
  assign nbr_b    = is_nbr(sel_b);
  assign illegal  = (nbr_a && nbr_b) || (op > OP_LAST);
  assign nbr_addr = nbr_a ? reg_a : reg_b;

  always_comb begin
    unique case (sel_a)
      SRC_OWN:   opnd_a = own_a;
      SRC_LEFT:  opnd_a = left_d;
      SRC_RIGHT: opnd_a = right_d;
      default:   opnd_a = imm;
    endcase
    unique case (sel_b)
      SRC_OWN:   opnd_b = own_b;
      SRC_LEFT:  opnd_b = left_d;
      SRC_RIGHT: opnd_b = right_d;
      default:   opnd_b = imm;
    endcase
  end
endmodule

// File: rtl/vliw_alu.sv
module vliw_alu
  import vliw_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic [2:0]       op,
  input  logic [REG_W-1:0] a,
  input  logic [REG_W-1:0] b,
  output logic [REG_W-1:0] y,
  output logic             carry
);
  logic [REG_W:0] sum, diff;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};

  always_comb begin
    carry = 1'b0;
    unique case (op)
      OP_ADD:  begin y = sum[REG_W-1:0];  carry = sum[REG_W];  end
      OP_SUB:  begin y = diff[REG_W-1:0]; carry = diff[REG_W]; end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/vliw_cluster_dp.sv
module vliw_cluster_dp #(
  parameter int N_CL  = 4,
  parameter int N_REG = 16,
  parameter int REG_W = 16,
  localparam int AW = $clog2(N_REG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CL-1:0]       slot_en,
  input  logic [N_CL*3-1:0]     slot_op,
  input  logic [N_CL*AW-1:0]    slot_dst,
  input  logic [N_CL*2-1:0]     slot_sel_a,
  input  logic [N_CL*AW-1:0]    slot_reg_a,
  input  logic [N_CL*2-1:0]     slot_sel_b,
  input  logic [N_CL*AW-1:0]    slot_reg_b,
  input  logic [N_CL*REG_W-1:0] slot_imm,
  output logic [N_CL-1:0]       res_valid,
  output logic [N_CL-1:0]       res_err,
  output logic [N_CL-1:0]       res_carry,
  output logic [N_CL*REG_W-1:0] res_data
);
  logic [AW-1:0]    nbr_addr [N_CL];
  logic [REG_W-1:0] q_a  [N_CL];
  logic [REG_W-1:0] q_b  [N_CL];
  logic [REG_W-1:0] q_up [N_CL];
  logic [REG_W-1:0] q_dn [N_CL];
  logic [REG_W-1:0] y_q  [N_CL];

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    localparam int LFT = (c + N_CL - 1) % N_CL;
    localparam int RGT = (c + 1) % N_CL;

    logic [2:0]       op;
    logic [REG_W-1:0] opa, opb, y;
    logic             ill, cy, wr;
    logic             v_q, e_q, c_q;

    assign op = slot_op[c*3 +: 3];
    assign wr = slot_en[c] && !ill;

    // up port serves the right neighbour's left read, dn the left neighbour's right read
    vliw_regbank #(.REG_W(REG_W), .N_REG(N_REG)) bank_i (
      .clk   (clk),
      .rst   (rst),
      .we    (wr),
      .waddr (slot_dst[c*AW +: AW]),
      .wdata (y),
      .ra_a  (slot_reg_a[c*AW +: AW]),
      .ra_b  (slot_reg_b[c*AW +: AW]),
      .ra_up (nbr_addr[RGT]),
      .ra_dn (nbr_addr[LFT]),
      .rd_a  (q_a[c]),
      .rd_b  (q_b[c]),
      .rd_up (q_up[c]),
      .rd_dn (q_dn[c])
    );

    vliw_opsel #(.REG_W(REG_W), .AW(AW)) sel_i (
      .op       (op),
      .sel_a    (slot_sel_a[c*2 +: 2]),
      .sel_b    (slot_sel_b[c*2 +: 2]),
      .reg_a    (slot_reg_a[c*AW +: AW]),
      .reg_b    (slot_reg_b[c*AW +: AW]),
      .imm      (slot_imm[c*REG_W +: REG_W]),
      .own_a    (q_a[c]),
      .own_b    (q_b[c]),
      .left_d   (q_up[LFT]),
      .right_d  (q_dn[RGT]),
      .nbr_addr (nbr_addr[c]),
      .opnd_a   (opa),
      .opnd_b   (opb),
      .illegal  (ill)
    );

    vliw_alu #(.REG_W(REG_W)) alu_i (
      .op    (op),
      .a     (opa),
      .b     (opb),
      .y     (y),
      .carry (cy)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q    <= 1'b0;
        e_q    <= 1'b0;
        c_q    <= 1'b0;
        y_q[c] <= '0;
      end else begin
        v_q    <= wr;
        e_q    <= slot_en[c] && ill;
        c_q    <= wr ? cy : 1'b0;
        y_q[c] <= wr ? y : '0;
      end
    end

    assign res_valid[c]              = v_q;
    assign res_err[c]                = e_q;
    assign res_carry[c]              = c_q;
    assign res_data[c*REG_W +: REG_W] = y_q[c];
  end
endmodule

// File: rtl/vliw_cluster_dp_chk.sv
module vliw_cluster_dp_chk
  import vliw_pkg::*;
#(
  parameter int N_CL  = 4,
  parameter int N_REG = 16,
  parameter int REG_W = 16,
  localparam int AW = $clog2(N_REG)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_CL-1:0]       slot_en,
  input logic [N_CL*3-1:0]     slot_op,
  input logic [N_CL*2-1:0]     slot_sel_a,
  input logic [N_CL*AW-1:0]    slot_reg_a,
  input logic [N_CL*2-1:0]     slot_sel_b,
  input logic [N_CL*AW-1:0]    slot_reg_b,
  input logic [N_CL*REG_W-1:0] slot_imm,
  input logic [N_CL-1:0]       res_valid,
  input logic [N_CL-1:0]       res_err,
  input logic [N_CL-1:0]       res_carry,
  input logic [N_CL*REG_W-1:0] res_data
);
  for (genvar i = 0; i < N_CL; i++) begin : g_chk
    logic [2:0]       op;
    logic [1:0]       sa, sb;
    logic             legal;
    logic [REG_W-1:0] d;

    assign op    = slot_op[i*3 +: 3];
    assign sa    = slot_sel_a[i*2 +: 2];
    assign sb    = slot_sel_b[i*2 +: 2];
    assign legal = !(is_nbr(sa) && is_nbr(sb)) && (op <= OP_LAST);
    assign d     = res_data[i*REG_W +: REG_W];

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!res_valid[i] && !res_err[i] && !res_carry[i] && d == '0)); // R1

    AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
      (slot_en[i] && op == OP_SUB && sa == SRC_OWN && sb == SRC_OWN &&
       slot_reg_a[i*AW +: AW] == slot_reg_b[i*AW +: AW])
      |=> (res_valid[i] && d == '0 && !res_carry[i])); // R2

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      (slot_en[i] && legal && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (res_valid[i] && !res_carry[i])); // R2

    AST_IMM_PASS: assert property (@(posedge clk) disable iff (rst)
      (slot_en[i] && op == OP_PASS && sa == SRC_IMM && !is_nbr(sb) || 
       slot_en[i] && op == OP_PASS && sa == SRC_IMM && sb == SRC_OWN)
      |=> (res_valid[i] && d == $past(slot_imm[i*REG_W +: REG_W]))); // R3

    AST_TWO_NEIGHBOURS: assert property (@(posedge clk) disable iff (rst)
      (slot_en[i] && is_nbr(sa) && is_nbr(sb)) |=> (res_err[i] && !res_valid[i])); // R6

    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
      !slot_en[i] |=> (!res_valid[i] && !res_err[i])); // R8
  end
endmodule

bind vliw_cluster_dp vliw_cluster_dp_chk #(
  .N_CL(N_CL), .N_REG(N_REG), .REG_W(REG_W)
) chk_i (.*);

// File: tb/vliw_cluster_dp_tb_top.sv
module vliw_cluster_dp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CL  = 4;
  localparam int N_REG = 16;
  localparam int REG_W = 16;
  localparam int AW    = 4;
  localparam int N_VEC = 17;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [N_CL-1:0]       slot_en;
  logic [N_CL*3-1:0]     slot_op;
  logic [N_CL*AW-1:0]    slot_dst;
  logic [N_CL*2-1:0]     slot_sel_a;
  logic [N_CL*AW-1:0]    slot_reg_a;
  logic [N_CL*2-1:0]     slot_sel_b;
  logic [N_CL*AW-1:0]    slot_reg_b;
  logic [N_CL*REG_W-1:0] slot_imm;
  logic [N_CL-1:0]       res_valid, res_err, res_carry;
  logic [N_CL*REG_W-1:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_cluster_dp #(.N_CL(N_CL), .N_REG(N_REG), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .slot_en(slot_en), .slot_op(slot_op),
    .slot_dst(slot_dst), .slot_sel_a(slot_sel_a), .slot_reg_a(slot_reg_a),
    .slot_sel_b(slot_sel_b), .slot_reg_b(slot_reg_b), .slot_imm(slot_imm),
    .res_valid(res_valid), .res_err(res_err), .res_carry(res_carry),
    .res_data(res_data)
  );

  typedef struct packed {
    logic [1:0]  s;
    logic [2:0]  op;
    logic [1:0]  sa;
    logic [3:0]  ra;
    logic [1:0]  sb;
    logic [3:0]  rb;
    logic [15:0] imm;
    logic [3:0]  dst;
    logic [15:0] ed;
    logic        ec;
    logic        ee;
    logic [3:0]  rq;
  } vec_t;

  // selectors: 0 own, 1 left, 2 right, 3 literal; ops: 0 add,1 sub,2 and,3 or,4 xor,5 pass
  localparam vec_t TBL [N_VEC] = '{
    '{2'd0, 3'd5, 2'd3, 4'd0, 2'd0, 4'd0, 16'h1234, 4'd1,  16'h1234, 1'b0, 1'b0, 4'd2}, // R2 load c0r1
    '{2'd1, 3'd5, 2'd3, 4'd0, 2'd0, 4'd0, 16'hFFFF, 4'd2,  16'hFFFF, 1'b0, 1'b0, 4'd2}, // R2 load c1r2
    '{2'd2, 3'd5, 2'd3, 4'd0, 2'd0, 4'd0, 16'h00F0, 4'd3,  16'h00F0, 1'b0, 1'b0, 4'd2}, // R2 load c2r3
    '{2'd3, 3'd5, 2'd3, 4'd0, 2'd0, 4'd0, 16'h8001, 4'd4,  16'h8001, 1'b0, 1'b0, 4'd2}, // R2 load c3r4
    '{2'd0, 3'd0, 2'd0, 4'd1, 2'd2, 4'd2, 16'h0000, 4'd5,  16'h1233, 1'b1, 1'b0, 4'd2}, // R2 wrap+carry, R3 right
    '{2'd1, 3'd0, 2'd1, 4'd1, 2'd3, 4'd0, 16'h0001, 4'd6,  16'h1235, 1'b0, 1'b0, 4'd3}, // R3 left
    '{2'd0, 3'd3, 2'd0, 4'd1, 2'd1, 4'd4, 16'h0000, 4'd7,  16'h9235, 1'b0, 1'b0, 4'd3}, // R3 ring left 0->3
    '{2'd3, 3'd4, 2'd2, 4'd1, 2'd0, 4'd4, 16'h0000, 4'd0,  16'h9235, 1'b0, 1'b0, 4'd3}, // R3 ring right 3->0
    '{2'd2, 3'd1, 2'd0, 4'd3, 2'd3, 4'd0, 16'h0100, 4'd2,  16'hFFF0, 1'b1, 1'b0, 4'd2}, // R2 borrow
    '{2'd2, 3'd2, 2'd0, 4'd2, 2'd1, 4'd2, 16'h0000, 4'd5,  16'hFFF0, 1'b0, 1'b0, 4'd3}, // R3 and with left
    '{2'd1, 3'd0, 2'd1, 4'd1, 2'd2, 4'd3, 16'h0000, 4'd9,  16'h0000, 1'b0, 1'b1, 4'd6}, // R6 two neighbours
    '{2'd1, 3'd5, 2'd0, 4'd9, 2'd0, 4'd0, 16'h0000, 4'd0,  16'h0000, 1'b0, 1'b0, 4'd6}, // R6 no write c1r9
    '{2'd0, 3'd6, 2'd0, 4'd1, 2'd0, 4'd1, 16'h0000, 4'd1,  16'h0000, 1'b0, 1'b1, 4'd6}, // R6 bad opcode
    '{2'd0, 3'd5, 2'd0, 4'd1, 2'd0, 4'd0, 16'h0000, 4'd11, 16'h1234, 1'b0, 1'b0, 4'd6}, // R6 c0r1 kept
    '{2'd3, 3'd1, 2'd0, 4'd4, 2'd0, 4'd4, 16'h0000, 4'd12, 16'h0000, 1'b0, 1'b0, 4'd2}, // R2 self subtract
    '{2'd0, 3'd0, 2'd0, 4'd5, 2'd3, 4'd0, 16'h0DCD, 4'd8,  16'h2000, 1'b0, 1'b0, 4'd2}, // R2 add literal
    '{2'd1, 3'd5, 2'd0, 4'd1, 2'd0, 4'd0, 16'h0000, 4'd10, 16'h0000, 1'b0, 1'b0, 4'd4}  // R4 c1r1 never written
  };

  task automatic clear_slots();
    slot_en = '0; slot_op = '0; slot_dst = '0; slot_sel_a = '0;
    slot_reg_a = '0; slot_sel_b = '0; slot_reg_b = '0; slot_imm = '0;
  endtask

  task automatic put(input int s, input logic [2:0] op, input logic [1:0] sa,
                     input logic [3:0] ra, input logic [1:0] sb, input logic [3:0] rb,
                     input logic [15:0] imm, input logic [3:0] dst);
    slot_en[s] = 1'b1;
    slot_op[s*3 +: 3] = op;
    slot_sel_a[s*2 +: 2] = sa;
    slot_reg_a[s*AW +: AW] = ra;
    slot_sel_b[s*2 +: 2] = sb;
    slot_reg_b[s*AW +: AW] = rb;
    slot_imm[s*REG_W +: REG_W] = imm;
    slot_dst[s*AW +: AW] = dst;
  endtask

  task automatic chk(input string req, input int s, input logic ev, input logic ee,
                     input logic [15:0] ed, input logic ec);
    logic [15:0] ad;
    ad = res_data[s*REG_W +: REG_W];
    n_chk++;
    if (res_valid[s] !== ev || res_err[s] !== ee ||
        (ev && (ad !== ed || res_carry[s] !== ec))) begin
      n_bad++;
      $display("FAIL %s slot%0d: valid=%0b err=%0b data=%h carry=%0b expected valid=%0b err=%0b data=%h carry=%0b",
               req, s, res_valid[s], res_err[s], ad, res_carry[s], ev, ee, ed, ec);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    clear_slots();
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    n_chk++;
    if (res_valid !== '0 || res_err !== '0 || res_carry !== '0 || res_data !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: v=%h e=%h c=%h d=%h expected all zero",
               res_valid, res_err, res_carry, res_data);
    end
    rst = 1'b0;

    // table walk: one slot per bundle, R9 result checked one clock later
    for (int k = 0; k < N_VEC; k++) begin
      clear_slots();
      put(TBL[k].s, TBL[k].op, TBL[k].sa, TBL[k].ra, TBL[k].sb, TBL[k].rb,
          TBL[k].imm, TBL[k].dst);
      @(negedge clk);
      chk($sformatf("R%0d/R9 vec%0d", TBL[k].rq, k), TBL[k].s, !TBL[k].ee,
          TBL[k].ee, TBL[k].ed, TBL[k].ec);
    end

    // R7 + R5: four slots together; slots 1 and 3 read c0r8 while slot 0 writes it
    clear_slots();
    put(0, 3'd0, 2'd0, 4'd8, 2'd3, 4'd0, 16'h0001, 4'd8);
    put(1, 3'd5, 2'd1, 4'd8, 2'd0, 4'd0, 16'h0000, 4'd3);
    put(2, 3'd5, 2'd3, 4'd0, 2'd0, 4'd0, 16'h0042, 4'd7);
    put(3, 3'd5, 2'd2, 4'd8, 2'd0, 4'd0, 16'h0000, 4'd1);
    @(negedge clk);
    chk("R7 slot0 add", 0, 1'b1, 1'b0, 16'h2001, 1'b0);
    chk("R5 slot1 old value", 1, 1'b1, 1'b0, 16'h2000, 1'b0);
    chk("R7 slot2 literal", 2, 1'b1, 1'b0, 16'h0042, 1'b0);
    chk("R5 slot3 old value", 3, 1'b1, 1'b0, 16'h2000, 1'b0);

    // R4: written values visible next bundle, each in its own bank
    clear_slots();
    put(0, 3'd5, 2'd0, 4'd8, 2'd0, 4'd0, 16'h0000, 4'd14);
    put(1, 3'd5, 2'd0, 4'd3, 2'd0, 4'd0, 16'h0000, 4'd14);
    put(3, 3'd5, 2'd0, 4'd1, 2'd0, 4'd0, 16'h0000, 4'd14);
    @(negedge clk);
    chk("R4 c0r8", 0, 1'b1, 1'b0, 16'h2001, 1'b0);
    chk("R4 c1r3", 1, 1'b1, 1'b0, 16'h2000, 1'b0);
    chk("R4 c3r1", 3, 1'b1, 1'b0, 16'h2000, 1'b0);
    chk("R8 idle slot2", 2, 1'b0, 1'b0, 16'h0000, 1'b0);

    // R8: disabled slot with a write-worthy bundle leaves c2r7 alone
    clear_slots();
    slot_op[2*3 +: 3] = 3'd5; slot_sel_a[2*2 +: 2] = 2'd3;
    slot_imm[2*REG_W +: REG_W] = 16'hDEAD; slot_dst[2*AW +: AW] = 4'd7;
    @(negedge clk);
    chk("R8 disabled slot", 2, 1'b0, 1'b0, 16'h0000, 1'b0);
    clear_slots();
    put(2, 3'd5, 2'd0, 4'd7, 2'd0, 4'd0, 16'h0000, 4'd15);
    @(negedge clk);
    chk("R8 c2r7 kept", 2, 1'b1, 1'b0, 16'h0042, 1'b0);

    // R1: reset mid-run clears banks
    clear_slots();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    put(0, 3'd5, 2'd0, 4'd1, 2'd0, 4'd0, 16'h0000, 4'd2);
    put(2, 3'd5, 2'd0, 4'd3, 2'd0, 4'd0, 16'h0000, 4'd4);
    @(negedge clk);
    chk("R1 c0r1 cleared", 0, 1'b1, 1'b0, 16'h0000, 1'b0);
    chk("R1 c2r3 cleared", 2, 1'b1, 1'b0, 16'h0000, 1'b0);

    clear_slots();
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule